// File: doc/BRIEF.md
# Buffered Pulse Pattern Output Register

This block is the 16-bit pattern output stage of a pulse generator. The pattern is split into a high byte and a low byte. Every output bit has a current-data flop and a next-data flop. A per-bit enable marks a bit as a pulse output. When an output trigger strobe arrives, each enabled bit loads its next-data value into its current-data flop. Bits that are not enabled keep their value. The current data drives the `pulse_out` bus directly.

A small CPU port writes and reads the current-data, next-data, enable and configuration registers. Writes complete at the clock edge, and reads are combinational from the address. The enable bit also protects its current-data bit from CPU writes. Software sets the initial output level while a bit is disabled, then enables the bit and lets the triggers step the pattern. A configuration bit chooses the trigger mode:

- **Shared mode:** one strobe updates both bytes.
- **Separate mode:** each byte has its own strobe.

The next-data bytes appear at a different address pair in each mode.

Top module: `pulse_pattern_out`

## Requirements
- R1: After reset, `pulse_out` is 0. The mode is shared (configuration bit 0 reads 0). All enable, current-data and next-data registers read 0.
- R2: The register map is as follows:
  - Address 0x0 is the configuration register. Bit 0 = 1 selects separate trigger mode.
  - 0x1 is the high enable byte and 0x2 is the low enable byte.
  - 0x3 is the high current-data byte and 0x4 is the low current-data byte.
  - 0x5 and 0x6 are next-data high and low in shared mode.
  - 0x8 and 0x9 are next-data high and low in separate mode.
  - Every other address reads 0.
- R3: On an effective trigger, every bit whose enable is 1 takes its next-data value on `pulse_out` one cycle later. Bits whose enable is 0 are unchanged.
- R4: A CPU write to a current-data byte updates every bit whose enable is 0. The new value shows on `pulse_out` and on read-back from the next cycle.
- R5: A CPU write to a current-data bit whose enable is 1 is ignored. The bit keeps its value on `pulse_out` and on read-back.
- R6: In shared mode, `trig_all` triggers both bytes. `trig_hi` and `trig_lo` have no effect.
- R7: In separate mode, `trig_hi` triggers only bits 15..8 and `trig_lo` triggers only bits 7..0. `trig_all` has no effect.
- R8: The next-data pair for the mode that is not selected reads 0, and writes to it are ignored. The stored next-data values are kept across mode changes.
- R9: If a CPU write to a current-data byte and an effective trigger occur in the same cycle, enabled bits take next-data and disabled bits take the written data.
- R10: The configuration, enable and next-data registers can always be written, and they read back the value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 4 | Register address |
| cpu_wr | input | 1 | Write strobe, one cycle per write |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data for `cpu_addr`, combinational |
| trig_all | input | 1 | Single-cycle trigger for both bytes in shared mode |
| trig_hi | input | 1 | Single-cycle high-byte trigger in separate mode |
| trig_lo | input | 1 | Single-cycle low-byte trigger in separate mode |
| pulse_out | output | 16 | Current pattern output |

## Verification
The hardest case to reach from the ports is a CPU write and a trigger landing on the same byte in the same cycle while the enable is only partly set. Both sources then compete bit by bit.

The bench reaches this case in four steps:
1. Preset a next-data value.
2. Set an enable mask of 0xF0.
3. Drive the current-data write and the trigger strobe on the same falling edge.
4. Check the merged nibbles on `pulse_out`.

The bench also flips the mode and strobes the trigger that the mode ignores. This shows that the inactive trigger inputs and the unused next-data address pair leave the state untouched.

// File: rtl/ppo_pkg.sv
// Shared constants and types for the pulse pattern output block.
// Assumes a 4-bit register address space and byte-wide registers.
package ppo_pkg;
    localparam int ADDR_W  = 4;
    localparam int BYTE_W  = 8;
    localparam int N_LANES = 2;
    localparam int OUT_W   = BYTE_W * N_LANES;

    localparam logic [ADDR_W-1:0] A_CFG     = 4'h0;
    localparam logic [ADDR_W-1:0] A_EN_HI   = 4'h1;
    localparam logic [ADDR_W-1:0] A_EN_LO   = 4'h2;
    localparam logic [ADDR_W-1:0] A_CUR_HI  = 4'h3;
    localparam logic [ADDR_W-1:0] A_CUR_LO  = 4'h4;
    localparam logic [ADDR_W-1:0] A_NSH_HI  = 4'h5;
    localparam logic [ADDR_W-1:0] A_NSH_LO  = 4'h6;
    localparam logic [ADDR_W-1:0] A_NSP_HI  = 4'h8;
    localparam logic [ADDR_W-1:0] A_NSP_LO  = 4'h9;

    // Per-lane register selects; index 1 = high byte, 0 = low byte.
    typedef struct packed {
        logic                cfg;
        logic [N_LANES-1:0]  en;
        logic [N_LANES-1:0]  cur;
        logic [N_LANES-1:0]  nxt;
    } reg_sel_t;
endpackage

// File: rtl/ppo_addr_decode.sv
// Address decoder: turns the CPU address into register selects.
// Next-data is selected at the shared pair or the separate pair,
// depending on the trigger mode; the other pair selects nothing.
module ppo_addr_decode
    import ppo_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              sep_mode,
    output reg_sel_t          sel
);
    // Combinational decode of the address into one-hot selects.
    always_comb begin
        sel        = '0;
        sel.cfg    = (addr == A_CFG);
        sel.en[1]  = (addr == A_EN_HI);
        sel.en[0]  = (addr == A_EN_LO);
        sel.cur[1] = (addr == A_CUR_HI);
        sel.cur[0] = (addr == A_CUR_LO);
        if (sep_mode) begin
            sel.nxt[1] = (addr == A_NSP_HI);
            sel.nxt[0] = (addr == A_NSP_LO);
        end else begin
            sel.nxt[1] = (addr == A_NSH_HI);
            sel.nxt[0] = (addr == A_NSH_LO);
        end
    end
endmodule

// File: rtl/ppo_byte_lane.sv
// One byte of the pattern. It holds the enable, next-data and
// current-data flops. A trigger loads next-data into the enabled
// bits. A CPU write reaches only the disabled current-data bits.
// The trigger strobe is one cycle wide. Both the write and the
// trigger use the enable value from before this edge.
module ppo_byte_lane #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic         wr_nxt,
    input  logic         wr_cur,
    input  logic [W-1:0] wdata,
    input  logic         trig,
    output logic [W-1:0] en_q,
    output logic [W-1:0] nxt_q,
    output logic [W-1:0] cur_q
);
    // Enable and next-data registers, always CPU writable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            nxt_q <= '0;
        end else begin
            if (wr_en)  en_q  <= wdata;
            if (wr_nxt) nxt_q <= wdata;
        end
    end

    for (genvar b = 0; b < W; b++) begin : g_bit
        // Per-bit current data: the trigger wins on enabled bits,
        // and the CPU can write only disabled bits.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cur_q[b] <= 1'b0;
            else if (en_q[b] && trig)
                cur_q[b] <= nxt_q[b];
            else if (!en_q[b] && wr_cur)
                cur_q[b] <= wdata[b];
        end
    end
endmodule

// File: rtl/pulse_pattern_out.sv
// Top of the buffered pulse pattern output. It holds the mode bit,
// routes the triggers to the two byte lanes, decodes the CPU
// address and multiplexes the read data.
// The trigger inputs are single-cycle strobes synchronous to clk.
module pulse_pattern_out
    import ppo_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_wr,
    input  logic [BYTE_W-1:0] cpu_wdata,
    output logic [BYTE_W-1:0] cpu_rdata,
    input  logic              trig_all,
    input  logic              trig_hi,
    input  logic              trig_lo,
    output logic [OUT_W-1:0]  pulse_out
);
    logic                cfg_sep;
    reg_sel_t            sel;
    logic [N_LANES-1:0]  lane_trig;
    logic [OUT_W-1:0]    en_all;
    logic [OUT_W-1:0]    nxt_all;
    logic [OUT_W-1:0]    cur_all;

    ppo_addr_decode u_dec (
        .addr     (cpu_addr),
        .sep_mode (cfg_sep),
        .sel      (sel)
    );

    // Trigger-mode configuration bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_sep <= 1'b0;
        else if (cpu_wr && sel.cfg)
            cfg_sep <= cpu_wdata[0];
    end

    // Route a trigger source to each lane according to the mode.
    always_comb begin
        lane_trig[1] = cfg_sep ? trig_hi : trig_all;
        lane_trig[0] = cfg_sep ? trig_lo : trig_all;
    end

    for (genvar l = 0; l < N_LANES; l++) begin : g_lane
        ppo_byte_lane #(.W(BYTE_W)) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (cpu_wr && sel.en[l]),
            .wr_nxt (cpu_wr && sel.nxt[l]),
            .wr_cur (cpu_wr && sel.cur[l]),
            .wdata  (cpu_wdata),
            .trig   (lane_trig[l]),
            .en_q   (en_all [l*BYTE_W +: BYTE_W]),
            .nxt_q  (nxt_all[l*BYTE_W +: BYTE_W]),
            .cur_q  (cur_all[l*BYTE_W +: BYTE_W])
        );
    end

    // Read multiplexer; unselected addresses return zero.
    always_comb begin
        cpu_rdata = '0;
        if (sel.cfg)    cpu_rdata = {{(BYTE_W-1){1'b0}}, cfg_sep};
        if (sel.en[1])  cpu_rdata = en_all [OUT_W-1 -: BYTE_W];
        if (sel.en[0])  cpu_rdata = en_all [BYTE_W-1:0];
        if (sel.cur[1]) cpu_rdata = cur_all[OUT_W-1 -: BYTE_W];
        if (sel.cur[0]) cpu_rdata = cur_all[BYTE_W-1:0];
        if (sel.nxt[1]) cpu_rdata = nxt_all[OUT_W-1 -: BYTE_W];
        if (sel.nxt[0]) cpu_rdata = nxt_all[BYTE_W-1:0];
    end

    assign pulse_out = cur_all;
endmodule

// File: rtl/ppo_checker.sv
// Checker for pulse_pattern_out. It is bound to the top and watches
// the trigger routing, the write lock and the reset state.
module ppo_checker
    import ppo_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             trig_all,
    input logic             trig_hi,
    input logic             trig_lo,
    input logic             sep,
    input logic [OUT_W-1:0] ena,
    input logic [OUT_W-1:0] nxt,
    input logic [OUT_W-1:0] pulse_out
);
    // R1: reset clears the output and the enables.
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (pulse_out == '0 && ena == '0));

    // R3 and R6: in shared mode, trig_all loads every enabled bit.
    a_r3_shared_load: assert property (@(posedge clk) disable iff (!rst_n)
        (!sep && trig_all) |=> (((pulse_out ^ $past(nxt)) & $past(ena)) == '0));

    // R7: in separate mode, trig_hi loads the enabled high bits.
    a_r7_sep_high: assert property (@(posedge clk) disable iff (!rst_n)
        (sep && trig_hi) |=>
        (((pulse_out[15:8] ^ $past(nxt[15:8])) & $past(ena[15:8])) == '0));

    // R7: in separate mode, trig_lo loads the enabled low bits.
    a_r7_sep_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sep && trig_lo) |=>
        (((pulse_out[7:0] ^ $past(nxt[7:0])) & $past(ena[7:0])) == '0));

    // R5: with no trigger, enabled bits hold whatever the CPU does.
    a_r5_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig_all && !trig_hi && !trig_lo) |=>
        (((pulse_out ^ $past(pulse_out)) & $past(ena)) == '0));

    // R6: in shared mode, the lane triggers cannot move enabled bits.
    a_r6_lane_trig_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!sep && !trig_all) |=>
        (((pulse_out ^ $past(pulse_out)) & $past(ena)) == '0));
endmodule

bind pulse_pattern_out ppo_checker u_ppo_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig_all  (trig_all),
    .trig_hi   (trig_hi),
    .trig_lo   (trig_lo),
    .sep       (cfg_sep),
    .ena       (en_all),
    .nxt       (nxt_all),
    .pulse_out (pulse_out)
);

// File: tb/pulse_pattern_out_bench.sv
// Directed bench for pulse_pattern_out. Each task drives one
// scenario and checks its own results. Inputs change on the
// falling edge; results are sampled on the following falling edge.
module pulse_pattern_out_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cpu_addr = '0;
    logic        cpu_wr = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        trig_all = 1'b0, trig_hi = 1'b0, trig_lo = 1'b0;
    logic [15:0] pulse_out;
    int n_chk = 0, n_bad = 0;

    always #5 clk = ~clk;

    pulse_pattern_out u_pulse_pattern_out (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .trig_all(trig_all),
        .trig_hi(trig_hi), .trig_lo(trig_lo), .pulse_out(pulse_out)
    );

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [7:0] d);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic rd_check(string req, logic [3:0] a, logic [7:0] exp);
        @(negedge clk);
        cpu_addr = a;
        #1;
        check(req, {8'h00, cpu_rdata}, {8'h00, exp});
    endtask

    // Strobe the given triggers for one cycle.
    task automatic pulse(logic ta, logic th, logic tl);
        @(negedge clk);
        trig_all = ta; trig_hi = th; trig_lo = tl;
        @(negedge clk);
        trig_all = 1'b0; trig_hi = 1'b0; trig_lo = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 out", pulse_out, 16'h0000);
        rd_check("R1 cfg", 4'h0, 8'h00);
        rd_check("R1 en_hi", 4'h1, 8'h00);
        rd_check("R1 nxt_lo", 4'h6, 8'h00);
        rd_check("R2 unmapped", 4'hF, 8'h00);
    endtask

    task automatic t_preset;
        wr(4'h3, 8'hA5);
        wr(4'h4, 8'h3C);
        check("R4 preset out", pulse_out, 16'hA53C);
        rd_check("R4 preset readback", 4'h3, 8'hA5);
    endtask

    task automatic t_regs;
        wr(4'h5, 8'h5A); wr(4'h6, 8'hC3);
        wr(4'h1, 8'hFF); wr(4'h2, 8'h0F);
        rd_check("R10 nxt_hi", 4'h5, 8'h5A);
        rd_check("R10 nxt_lo", 4'h6, 8'hC3);
        rd_check("R10 en_lo", 4'h2, 8'h0F);
    endtask

    task automatic t_lock;
        wr(4'h3, 8'h00);
        wr(4'h4, 8'hFF);
        // The high byte is fully enabled; low bits 3..0 are enabled.
        check("R5 write lock", pulse_out, 16'hA5F0 | 16'h000C);
        rd_check("R5 locked readback", 4'h3, 8'hA5);
    endtask

    task automatic t_shared;
        // Lane triggers in shared mode have no effect.
        pulse(1'b0, 1'b1, 1'b1);
        check("R6 lane trig ignored", pulse_out, 16'hA5FC);
        pulse(1'b1, 1'b0, 1'b0);
        // High gets 5A; low upper nibble kept (F), low nibble takes 3.
        check("R3 shared load", pulse_out, 16'h5AF3);
    endtask

    task automatic t_separate;
        wr(4'h0, 8'h01);
        rd_check("R8 shared pair hidden", 4'h5, 8'h00);
        rd_check("R8 sep pair maps", 4'h8, 8'h5A);
        wr(4'h8, 8'h11); wr(4'h9, 8'h22);
        pulse(1'b1, 1'b0, 1'b0);
        check("R7 trig_all ignored", pulse_out, 16'h5AF3);
        pulse(1'b0, 1'b1, 1'b0);
        check("R7 high only", pulse_out, 16'h11F3);
        pulse(1'b0, 1'b0, 1'b1);
        check("R7 low only", pulse_out, 16'h11F2);
        wr(4'h5, 8'hEE);
        wr(4'h0, 8'h00);
        rd_check("R8 write to hidden pair ignored", 4'h5, 8'h11);
        rd_check("R8 sep pair hidden", 4'h9, 8'h00);
    endtask

    task automatic t_collision;
        wr(4'h5, 8'h3C);
        wr(4'h1, 8'hF0);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_addr = 4'h3; cpu_wdata = 8'h99; trig_all = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0; trig_all = 1'b0;
        check("R9 collision merge", pulse_out, 16'h39F2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_preset;
        t_regs;
        t_lock;
        t_shared;
        t_separate;
        t_collision;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule